// File: doc/BRIEF.md
# Dual-Converter Serial Result Shifter

This block is the device side of a serial readout port for a sampling ADC that has two converters, each with two input channels. The analog conversion is replaced by two parallel 12-bit result inputs, one per converter. Each conversion is sent as a 16-bit word: a leading zero, then three status bits, then the twelve result bits. The status bits give the input range, the channel, and which converter produced the result.

A host pulls the active-low chip select low and then toggles the serial clock. Both data lines shift at the same time: line A carries converter A's word and line B carries converter B's word. If the host keeps chip select low for sixteen more clocks, each line then carries the other converter's word. A single-port host can therefore read both results from one line.

The block runs on a fast system clock. Chip select and the serial clock are sampled as levels, and their edges are found internally. Each output pin has its own enable signal that models three-state release.

Top module: `adc_result_shifter`

## Requirements
- R1: After reset, and whenever chip select has been high for at least one system clock, both enables are low and both data outputs read 0.
- R2: One system clock after chip select is seen falling, both enables go high and both lines show the leading zero. The leading zero is frame bit 15, which is always 0.
- R3: The frame is sent MSB first. Word bit 13 is the channel bit, captured from `chan_sel` at the chip-select fall: 0 means channel 1 and 1 means channel 2. Word bit 12 is the converter bit: 0 for converter A and 1 for converter B. Each of these bits appears after the serial-clock falling edge whose count matches its position in the word.
- R4: Word bits 11 down to 0 carry the result MSB first. After the k-th serial-clock falling edge of the frame (k = 4 to 15), result bit 15-k is on the line.
- R5: A serial-clock rising edge does not change either data output. A system clock with no edge on either input does not change them either.
- R6: If chip select stays low, falling edges 16 to 31 send a second word. On line A this word carries converter B's result and header, and on line B it carries converter A's. The leading zero of the second word appears after falling edge 16.
- R7: The 32nd serial-clock rising edge of a frame releases both lines: the enables go low and the outputs read 0. They stay released until the next chip-select fall.
- R8: A chip-select rise at any point in the frame releases both lines one system clock later.
- R9: Word bit 14 is the range bit. It carries the value of `range_sel` captured at the chip-select fall of the previous frame, and it reads 0 in the first frame after reset. `range_sel` is captured at every chip-select fall.
- R10: Serial-clock edges while chip select is high leave both lines released. They do not shift the next frame, which still starts with its leading zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample chip select and the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host, idles high |
| range_sel | input | 1 | Input-range selection, captured at each chip-select fall |
| chan_sel | input | 1 | Channel that was converted, captured at each chip-select fall |
| res_a | input | 12 | Converter A result |
| res_b | input | 12 | Converter B result |
| dout_a | output | 1 | Serial data, line A (0 while released) |
| oe_a | output | 1 | Drive enable for line A |
| dout_b | output | 1 | Serial data, line B (0 while released) |
| oe_b | output | 1 | Drive enable for line B |

## Verification
Frames are run with all-zero, all-one, alternating, walking-one and other result patterns. Line B's result is always chosen different from line A's, so a swapped lane or a swapped second word shows up. The channel and range inputs are varied frame by frame, with a toggle pattern that separates range values from the previous frame and the current one. Frame lengths of 5, 16 and 32 serial clocks test early release, normal release and the automatic release on the 32nd rising edge. Serial-clock bursts with chip select high show whether idle activity leaks into the shift path.

// File: rtl/adc_shift_pkg.sv
package adc_shift_pkg;
  localparam int RES_W = 12;
  localparam int HDR_W = 4;

  typedef struct packed {
    logic lead;
    logic rng;
    logic chan;
    logic conv;
  } hdr_t;
endpackage

// File: rtl/ser_edge_detect.sv
module ser_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  output logic cs_fall,
  output logic cs_rise,
  output logic sclk_fall,
  output logic sclk_rise
);
  logic cs_prev;
  logic sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev   <= 1'b1;
      sclk_prev <= 1'b0;
    end else begin
      cs_prev   <= cs_n;
      sclk_prev <= sclk;
    end
  end

  assign cs_fall   = cs_prev & ~cs_n;
  assign cs_rise   = ~cs_prev & cs_n;
  assign sclk_fall = sclk_prev & ~sclk;
  assign sclk_rise = ~sclk_prev & sclk;
endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl #(
  parameter int TOTAL_BITS = 32,
  parameter int CNT_W      = $clog2(TOTAL_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             sclk_fall,
  input  logic             sclk_rise,
  output logic             active,
  output logic             load_ev,
  output logic             shift_ev,
  output logic             last_rise_ev,
  output logic             rel_ev,
  output logic [CNT_W-1:0] rise_cnt
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(TOTAL_BITS - 1);

  assign load_ev      = cs_fall;
  assign shift_ev     = active & sclk_fall & ~cs_fall;
  assign last_rise_ev = active & sclk_rise & (rise_cnt == LAST_IDX);
  assign rel_ev       = active & (cs_rise | last_rise_ev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      rise_cnt <= '0;
    end else if (load_ev) begin
      active   <= 1'b1;
      rise_cnt <= '0;
    end else begin
      if (rel_ev) active <= 1'b0;
      if (active && sclk_rise) rise_cnt <= rise_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/shift_lane.sv
module shift_lane
  import adc_shift_pkg::*;
#(
  parameter int     DATA_W  = RES_W,
  parameter logic   CONV_ID = 1'b0,
  localparam int    WORD_W  = DATA_W + HDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic              active,
  input  logic              rng,
  input  logic              chan,
  input  logic [DATA_W-1:0] own_res,
  input  logic [DATA_W-1:0] other_res,
  output logic              dout
);
  function automatic logic [WORD_W-1:0] make_word(
    input logic r, input logic c, input logic conv, input logic [DATA_W-1:0] d);
    hdr_t h;
    h.lead = 1'b0;
    h.rng  = r;
    h.chan = c;
    h.conv = conv;
    return {h, d};
  endfunction

  logic [2*WORD_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
    end else if (load) begin
      shreg <= {make_word(rng, chan, CONV_ID, own_res),
                make_word(rng, chan, ~CONV_ID, other_res)};
    end else if (shift) begin
      shreg <= {shreg[2*WORD_W-2:0], 1'b0};
    end
  end

  assign dout = active & shreg[2*WORD_W-1];
endmodule

// File: rtl/adc_result_shifter.sv
module adc_result_shifter
  import adc_shift_pkg::*;
#(
  parameter int DATA_W = RES_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              range_sel,
  input  logic              chan_sel,
  input  logic [DATA_W-1:0] res_a,
  input  logic [DATA_W-1:0] res_b,
  output logic              dout_a,
  output logic              oe_a,
  output logic              dout_b,
  output logic              oe_b
);
  localparam int WORD_W     = DATA_W + HDR_W;
  localparam int TOTAL_BITS = 2 * WORD_W;
  localparam int CNT_W      = $clog2(TOTAL_BITS + 1);

  logic cs_fall, cs_rise, sclk_fall, sclk_rise;
  logic active, load_ev, shift_ev, last_rise_ev, rel_ev;
  logic [CNT_W-1:0] rise_cnt;
  logic range_q;
  logic [1:0] lane_dout;

  ser_edge_detect u_edges (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .cs_fall   (cs_fall),
    .cs_rise   (cs_rise),
    .sclk_fall (sclk_fall),
    .sclk_rise (sclk_rise)
  );

  frame_ctrl #(.TOTAL_BITS(TOTAL_BITS), .CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_fall      (cs_fall),
    .cs_rise      (cs_rise),
    .sclk_fall    (sclk_fall),
    .sclk_rise    (sclk_rise),
    .active       (active),
    .load_ev      (load_ev),
    .shift_ev     (shift_ev),
    .last_rise_ev (last_rise_ev),
    .rel_ev       (rel_ev),
    .rise_cnt     (rise_cnt)
  );

  // Range captured now is reported in the following frame.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) range_q <= 1'b0;
    else if (load_ev) range_q <= range_sel;
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    shift_lane #(.DATA_W(DATA_W), .CONV_ID(g[0])) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_ev),
      .shift     (shift_ev),
      .active    (active),
      .rng       (range_q),
      .chan      (chan_sel),
      .own_res   ((g == 0) ? res_a : res_b),
      .other_res ((g == 0) ? res_b : res_a),
      .dout      (lane_dout[g])
    );
  end

  assign dout_a = lane_dout[0];
  assign dout_b = lane_dout[1];
  assign oe_a   = active;
  assign oe_b   = active;
endmodule

// File: rtl/adc_result_shifter_chk.sv
module adc_result_shifter_chk #(
  parameter int TOTAL_BITS = 32,
  parameter int CNT_W      = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             dout_a,
  input logic             dout_b,
  input logic             oe_a,
  input logic             oe_b,
  input logic             load_ev,
  input logic             shift_ev,
  input logic             rel_ev,
  input logic [CNT_W-1:0] rise_cnt
);
  // R1
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> (!oe_a && !oe_b && !dout_a && !dout_b));

  // R2
  lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(oe_a) || $rose(oe_b)) |-> (!dout_a && !dout_b));

  // R5
  hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_a && $past(oe_a) && !$past(shift_ev) && !$past(load_ev)) |-> $stable(dout_a));

  // R5
  hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_b && $past(oe_b) && !$past(shift_ev) && !$past(load_ev)) |-> $stable(dout_b));

  // R7
  release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_a) |-> $past(rel_ev));

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_cnt <= CNT_W'(TOTAL_BITS));
endmodule

bind adc_result_shifter adc_result_shifter_chk #(
  .TOTAL_BITS(TOTAL_BITS),
  .CNT_W(CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .dout_a   (dout_a),
  .dout_b   (dout_b),
  .oe_a     (oe_a),
  .oe_b     (oe_b),
  .load_ev  (load_ev),
  .shift_ev (shift_ev),
  .rel_ev   (rel_ev),
  .rise_cnt (rise_cnt)
);

// File: tb/adc_result_shifter_tb.sv
module adc_result_shifter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b1;
  logic range_sel = 1'b0;
  logic chan_sel = 1'b0;
  logic [11:0] res_a = '0;
  logic [11:0] res_b = '0;
  logic dout_a, oe_a, dout_b, oe_b;

  int errs = 0;
  int checks = 0;
  logic rng_prev = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  adc_result_shifter u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .range_sel(range_sel), .chan_sel(chan_sel), .res_a(res_a), .res_b(res_b),
    .dout_a(dout_a), .oe_a(oe_a), .dout_b(dout_b), .oe_b(oe_b)
  );

  task automatic chk(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_line(input string req, input logic ea, input logic eb, input logic eoe);
    chk(dout_a == ea && dout_b == eb && oe_a == eoe && oe_b == eoe, req,
        {dout_a, dout_b, oe_a, oe_b}, {ea, eb, eoe, eoe});
  endtask

  task automatic run_frame(input logic [11:0] a, input logic [11:0] b,
                           input logic ch, input logic rg, input int n_rises);
    logic [15:0] wa, wb;
    logic [31:0] sa, sb;
    string req;
    wa = {1'b0, rng_prev, ch, 1'b0, a};
    wb = {1'b0, rng_prev, ch, 1'b1, b};
    sa = {wa, wb};
    sb = {wb, wa};
    range_sel = rg; chan_sel = ch; res_a = a; res_b = b;
    cs_n = 1'b0;
    step(2);
    chk_line("R2", sa[31], sb[31], 1'b1);
    rng_prev = rg;
    for (int i = 1; i <= n_rises; i++) begin
      sclk = 1'b0;
      step(2);
      if (i == 1) req = "R9";
      else if (i <= 3) req = "R3";
      else if (i <= 15) req = "R4";
      else req = "R6";
      if (i <= 31) chk_line(req, sa[31-i], sb[31-i], 1'b1);
      sclk = 1'b1;
      step(2);
      if (i < 32) chk_line("R5", sa[31-i], sb[31-i], 1'b1);
      else chk_line("R7", 1'b0, 1'b0, 1'b0);
    end
    if (n_rises == 32) begin
      sclk = 1'b0; step(2); sclk = 1'b1; step(2);
      chk_line("R7", 1'b0, 1'b0, 1'b0);
    end
    cs_n = 1'b1;
    step(2);
    chk_line("R8", 1'b0, 1'b0, 1'b0);
    step(2);
    chk_line("R1", 1'b0, 1'b0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [11:0] pa, pb;
    int nr;
    step(3);
    chk_line("R1", 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    step(2);
    chk_line("R1", 1'b0, 1'b0, 1'b0);

    // R10: serial clock activity with chip select high
    for (int k = 0; k < 5; k++) begin
      sclk = 1'b0; step(2);
      chk_line("R10", 1'b0, 1'b0, 1'b0);
      sclk = 1'b1; step(2);
      chk_line("R10", 1'b0, 1'b0, 1'b0);
    end

    for (int p = 0; p < 16; p++) begin
      case (p % 6)
        0: pa = 12'h000;
        1: pa = 12'hFFF;
        2: pa = 12'hAAA;
        3: pa = 12'h001 << p;
        4: pa = 12'h5A3 ^ (12'(p) * 12'h111);
        default: pa = 12'hC3C;
      endcase
      pb = ~pa ^ (12'h800 >> p);
      nr = (p % 3 == 0) ? 32 : ((p % 3 == 1) ? 16 : 5);
      run_frame(pa, pb, p[0], p[1] ^ p[2], nr);
      if (p == 7) begin
        // R10: idle burst between frames must not disturb the next one
        for (int k = 0; k < 3; k++) begin
          sclk = 1'b0; step(2); sclk = 1'b1; step(2);
        end
        chk_line("R10", 1'b0, 1'b0, 1'b0);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule